// File: doc/BRIEF.md
# Flash Write-Protection Release Sequencer

This controller lifts software write protection from a serial flash device. After a start pulse it reads the device status byte and decides whether any protection bits are set. If they are, it writes back a cleaned copy of that byte and reads the status again to confirm the result. It never talks to the serial pins itself. Reads go through a request/acknowledge status-read port. Writes go through an external write sequencer, which performs the enable opcode and the status write and reports completion or an error.

A two-bit variant code selects the protection layout. One layout is a plain protect field with no lock stage. Another has a top lock bit that can be released only while the hardware write-protect pin is released. The third has a top write-protect-enable bit. For the two layouts with a lock bit, the block first writes a byte with only the lock bit cleared, and then performs the global clear. When the operation ends, the block raises a one-cycle done pulse and holds a pass/fail verdict until the next start. It also holds two flags: one for a refusal caused by the hardware pin, and one for an error reported by the write sequencer.

Top module: `blkp_clear_seq`

## Requirements
- R1: The variant code selects the check mask and the clear mask. Code 0 uses check 0x3C and clear 0x3C. Code 1 uses check 0x0C and clear 0xBC, and has a lock stage with a pin test. Code 2 uses check 0x7C and clear 0xFC, and has a lock stage without a pin test. Code 3 behaves exactly like code 0.
- R2: If the first status read ANDed with the check mask is zero, the operation ends with pass=1 and no write request.
- R3: For code 1, if status bit 7 is 1 and bit 4 is 0 (pin asserted), the operation ends with pass=0 and wp_refused=1, and no write is requested.
- R4: For codes 1 and 2, if status bit 7 is 1 and no refusal applies, the first write carries the first-read status with only bit 7 cleared.
- R5: The global-clear write carries the first-read status with the clear-mask bits cleared. It follows the lock write when one was issued, and it never uses a value read later.
- R6: After the global clear, the status is read again. pass is 1 exactly when that value ANDed with the check mask is zero.
- R7: If wr_err is 1 together with wr_done, the operation ends at once with pass=0 and seq_err=1, and no further read or write is requested.
- R8: A start pulse, and the variant code, are ignored while busy is 1.
- R9: rd_req stays high until rd_ack. wr_req stays high, with wr_data stable, until wr_done.
- R10: After reset all outputs are 0. done is a single-cycle pulse. pass, wp_refused and seq_err hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| variant | input | 2 | Protection layout code, sampled together with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Protection is confirmed cleared |
| wp_refused | output | 1 | Lock release refused because the hardware pin is asserted |
| seq_err | output | 1 | The write sequencer reported an error |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Status read completes; rd_data is valid |
| rd_data | input | 8 | Status byte returned by the read |
| wr_req | output | 1 | Status write request to the write sequencer |
| wr_data | output | 8 | Status byte to be written |
| wr_done | input | 1 | Write sequencer finished the request |
| wr_err | input | 1 | Write failed; valid together with wr_done |

## Verification
The bench sweeps all 256 status values for every variant code against a bench model of the flash. The sweep is repeated with individual protect bits made sticky in the model, so that a design which trusts its write without reading back would report a false pass. Error injection on the first and on the second write catches a design that carries on after a sequencer failure, or that writes the global clear after a failed lock write. The pin-asserted case of code 1 catches a design that writes anyway. Some operations also pulse start with a different variant code while busy; a design that re-samples the variant code then would produce the wrong write values.

// File: rtl/blkp_pkg.sv
package blkp_pkg;

    localparam int SR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_DECIDE,
        ST_WR_LOCK,
        ST_WR_CLEAR,
        ST_RD_CHECK
    } state_e;

    typedef struct packed {
        state_e            st;
        logic [1:0]        var_sel;
        logic [SR_W-1:0]   snap;
        logic [SR_W-1:0]   wdata;
        logic              rd_req;
        logic              wr_req;
        logic              done;
        logic              pass;
        logic              refused;
        logic              err;
    } ctl_s;

endpackage

// File: rtl/blkp_variant_dec.sv
module blkp_variant_dec #(
    parameter int              SR_W      = 8,
    parameter logic [SR_W-1:0] GEN_MASK  = 8'h3C,
    parameter logic [SR_W-1:0] SEC_CHECK = 8'h0C,
    parameter logic [SR_W-1:0] SEC_CLEAR = 8'hBC,
    parameter logic [SR_W-1:0] WPE_CHECK = 8'h7C,
    parameter logic [SR_W-1:0] WPE_CLEAR = 8'hFC
) (
    input  logic [1:0]      var_sel,
    output logic [SR_W-1:0] check_mask,
    output logic [SR_W-1:0] clear_mask,
    output logic            lock_stage,
    output logic            pin_gate
);

    always_comb begin
        check_mask = GEN_MASK;
        clear_mask = GEN_MASK;
        lock_stage = 1'b0;
        pin_gate   = 1'b0;
        case (var_sel)
            2'd1: begin
                check_mask = SEC_CHECK;
                clear_mask = SEC_CLEAR;
                lock_stage = 1'b1;
                pin_gate   = 1'b1;
            end
            2'd2: begin
                check_mask = WPE_CHECK;
                clear_mask = WPE_CLEAR;
                lock_stage = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: only layouts with a lock stage may demand the pin test
    always_comb begin
        p_pin_needs_lock_r1: assert (!pin_gate || lock_stage);
    end

endmodule

// File: rtl/blkp_lock_eval.sv
module blkp_lock_eval #(
    parameter int SR_W     = 8,
    parameter int LOCK_BIT = 7,
    parameter int PIN_BIT  = 4
) (
    input  logic [SR_W-1:0] snap,
    input  logic [SR_W-1:0] check_mask,
    input  logic            lock_stage,
    input  logic            pin_gate,
    output logic            already_clear,
    output logic            need_lock,
    output logic            refused
);

    logic lock_set;
    logic pin_asserted;

    assign lock_set      = snap[LOCK_BIT];
    assign pin_asserted  = ~snap[PIN_BIT];
    assign already_clear = ((snap & check_mask) == '0);
    assign refused       = lock_stage & pin_gate & lock_set & pin_asserted;
    assign need_lock     = lock_stage & lock_set & ~refused;

endmodule

// File: rtl/blkp_clear_seq.sv
module blkp_clear_seq
    import blkp_pkg::*;
#(
    parameter int              LOCK_BIT  = 7,
    parameter int              PIN_BIT   = 4,
    parameter logic [SR_W-1:0] GEN_MASK  = 8'h3C,
    parameter logic [SR_W-1:0] SEC_CHECK = 8'h0C,
    parameter logic [SR_W-1:0] SEC_CLEAR = 8'hBC,
    parameter logic [SR_W-1:0] WPE_CHECK = 8'h7C,
    parameter logic [SR_W-1:0] WPE_CLEAR = 8'hFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      variant,
    output logic            busy,
    output logic            done,
    output logic            pass,
    output logic            wp_refused,
    output logic            seq_err,
    output logic            rd_req,
    input  logic            rd_ack,
    input  logic [SR_W-1:0] rd_data,
    output logic            wr_req,
    output logic [SR_W-1:0] wr_data,
    input  logic            wr_done,
    input  logic            wr_err
);

    localparam logic [SR_W-1:0] LOCK_ONEHOT = SR_W'(1) << LOCK_BIT;
    localparam ctl_s CTL_RST = '{st: ST_IDLE, default: '0};

    ctl_s q, d;

    logic [SR_W-1:0] check_mask;
    logic [SR_W-1:0] clear_mask;
    logic            lock_stage;
    logic            pin_gate;
    logic            already_clear;
    logic            need_lock;
    logic            refused;

    blkp_variant_dec #(
        .SR_W      (SR_W),
        .GEN_MASK  (GEN_MASK),
        .SEC_CHECK (SEC_CHECK),
        .SEC_CLEAR (SEC_CLEAR),
        .WPE_CHECK (WPE_CHECK),
        .WPE_CLEAR (WPE_CLEAR)
    ) u_dec (
        .var_sel    (q.var_sel),
        .check_mask (check_mask),
        .clear_mask (clear_mask),
        .lock_stage (lock_stage),
        .pin_gate   (pin_gate)
    );

    blkp_lock_eval #(
        .SR_W     (SR_W),
        .LOCK_BIT (LOCK_BIT),
        .PIN_BIT  (PIN_BIT)
    ) u_eval (
        .snap          (q.snap),
        .check_mask    (check_mask),
        .lock_stage    (lock_stage),
        .pin_gate      (pin_gate),
        .already_clear (already_clear),
        .need_lock     (need_lock),
        .refused       (refused)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_RD_FIRST;
                    d.var_sel = variant;
                    d.rd_req  = 1'b1;
                    d.pass    = 1'b0;
                    d.refused = 1'b0;
                    d.err     = 1'b0;
                end
            end
            ST_RD_FIRST: begin
                if (rd_ack) begin
                    d.snap   = rd_data;
                    d.rd_req = 1'b0;
                    d.st     = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (already_clear) begin
                    d.pass = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (refused) begin
                    d.refused = 1'b1;
                    d.done    = 1'b1;
                    d.st      = ST_IDLE;
                end else if (need_lock) begin
                    d.wdata  = q.snap & ~LOCK_ONEHOT;
                    d.wr_req = 1'b1;
                    d.st     = ST_WR_LOCK;
                end else begin
                    d.wdata  = q.snap & ~clear_mask;
                    d.wr_req = 1'b1;
                    d.st     = ST_WR_CLEAR;
                end
            end
            ST_WR_LOCK: begin
                if (wr_done) begin
                    if (wr_err) begin
                        d.wr_req = 1'b0;
                        d.err    = 1'b1;
                        d.done   = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.wdata = q.snap & ~clear_mask;
                        d.st    = ST_WR_CLEAR;
                    end
                end
            end
            ST_WR_CLEAR: begin
                if (wr_done) begin
                    d.wr_req = 1'b0;
                    if (wr_err) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.rd_req = 1'b1;
                        d.st     = ST_RD_CHECK;
                    end
                end
            end
            ST_RD_CHECK: begin
                if (rd_ack) begin
                    d.rd_req = 1'b0;
                    d.pass   = ((rd_data & check_mask) == '0);
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign pass       = q.pass;
    assign wp_refused = q.refused;
    assign seq_err    = q.err;
    assign rd_req     = q.rd_req;
    assign wr_req     = q.wr_req;
    assign wr_data    = q.wdata;

    // tracks whether the current operation issued any write
    logic op_wrote_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               op_wrote_q <= 1'b0;
        else if (!busy && start)  op_wrote_q <= 1'b0;
        else if (wr_req)          op_wrote_q <= 1'b1;
    end

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_done |=> wr_req && $stable(wr_data));

    p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_done && wr_err |=> !wr_req && !rd_req && done && seq_err);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(q.var_sel));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_refuse_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && wp_refused |-> !op_wrote_q);

    p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(pass && (wp_refused || seq_err)));

endmodule

// File: tb/blkp_clear_seq_tb.sv
module blkp_clear_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] variant = 2'd0;
    logic       busy, done, pass, wp_refused, seq_err;
    logic       rd_req, wr_req;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;
    logic       wr_done = 1'b0;
    logic       wr_err = 1'b0;

    always #4 clk = ~clk;

    blkp_clear_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .variant    (variant),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .wp_refused (wp_refused),
        .seq_err    (seq_err),
        .rd_req     (rd_req),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .wr_done    (wr_done),
        .wr_err     (wr_err)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash status model
    logic [7:0] fsr = 8'h00;
    logic [7:0] stuck = 8'h00;
    int         err_at = -1;
    int         lat = 0;
    int         wcount = 0;
    logic [7:0] wlog [4];
    int         rd_cnt = 0;
    int         wr_cnt = 0;
    logic [7:0] wr_first = 8'h00;

    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (rd_cnt >= lat) begin
                rd_ack  = 1'b1;
                rd_data = fsr;
                rd_cnt  = 0;
            end else begin
                rd_cnt++;
            end
        end else if (rd_cnt != 0) begin
            check(1'b0, "R9 rd_req dropped", 0, 1);
            rd_cnt = 0;
        end

        if (wr_done) begin
            wr_done = 1'b0;
            wr_err  = 1'b0;
        end else if (wr_req) begin
            if (wr_cnt == 0) wr_first = wr_data;
            if (wr_cnt >= lat) begin
                check(wr_data == wr_first, "R9 wr_data stable", wr_data, wr_first);
                wr_done = 1'b1;
                if (wcount < 4) wlog[wcount] = wr_data;
                if (wcount == err_at) wr_err = 1'b1;
                else fsr = wr_data | (fsr & stuck);
                wcount++;
                wr_cnt = 0;
            end else begin
                wr_cnt++;
            end
        end
    end

    task automatic run_op(input logic [1:0] v, input logic [7:0] s, input logic [7:0] stk,
                          input int eidx, input int l, input bit interfere, input string force_tag);
        logic [7:0] chk, clr;
        logic [7:0] w [2];
        int         n = 0;
        bit         e_pass = 0, e_ref = 0, e_err = 0;
        int         tmo = 0;
        string      tg;
        logic [7:0] fin;
        fsr = s; stuck = stk; err_at = eidx; lat = l; wcount = 0;
        @(negedge clk);
        start = 1'b1; variant = v;
        @(negedge clk);
        if (interfere) begin
            start = 1'b1; variant = v ^ 2'd1;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        while (!done && tmo < 500) begin
            @(negedge clk);
            tmo++;
        end
        check(tmo < 500, "R10 done timeout", tmo, 0);

        // expected result from the requirements
        case (v)
            2'd1:    begin chk = 8'h0C; clr = 8'hBC; end
            2'd2:    begin chk = 8'h7C; clr = 8'hFC; end
            default: begin chk = 8'h3C; clr = 8'h3C; end
        endcase
        if ((s & chk) == 8'h00) begin
            e_pass = 1; tg = "R2";
        end else if (v == 2'd1 && s[7] && !s[4]) begin
            e_ref = 1; tg = "R3";
        end else begin
            if ((v == 2'd1 || v == 2'd2) && s[7]) begin
                w[n] = s & 8'h7F; n++;
            end
            w[n] = s & ~clr; n++;
            if (eidx >= 0 && eidx < n) begin
                e_err = 1; n = eidx + 1; tg = "R7";
            end else begin
                fin = w[n-1] | (s & stk);
                e_pass = ((fin & chk) == 8'h00);
                tg = "R6";
            end
        end
        if (force_tag != "") tg = force_tag;
        if (interfere) tg = {tg, "/R8"};

        check(pass == e_pass, {tg, " pass"}, pass, e_pass);
        check(wp_refused == e_ref, {tg, " wp_refused"}, wp_refused, e_ref);
        check(seq_err == e_err, {tg, " seq_err"}, seq_err, e_err);
        check(wcount == n, {tg, " write count"}, wcount, n);
        for (int i = 0; i < n && i < 2; i++) begin
            if (i == 0 && n >= 2)
                check(wlog[i] == w[i], {tg, " R4 lock write"}, wlog[i], w[i]);
            else
                check(wlog[i] == w[i], {tg, " R5 clear write"}, wlog[i], w[i]);
        end
        @(negedge clk);
        check(done == 1'b0 && pass == e_pass && busy == 1'b0, "R10 pulse/hold",
              {done, pass, busy}, {1'b0, e_pass, 1'b0});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, pass, wp_refused, seq_err, rd_req, wr_req} == 7'b0,
              "R10 reset state", {busy, done, pass, wp_refused, seq_err, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 3; v++)
            for (int s = 0; s < 256; s++)
                run_op(v[1:0], s[7:0], 8'h00, -1, s % 3, (s % 4) == 3, "");

        for (int v = 0; v < 3; v++)
            for (int s = 0; s < 256; s++)
                run_op(v[1:0], s[7:0], 8'h04 << (s % 5), -1, s % 2, 1'b0, "");

        for (int v = 0; v < 3; v++)
            for (int s = 0; s < 256; s++)
                run_op(v[1:0], s[7:0], 8'h00, s % 2, s % 2, 1'b0, "");

        for (int s = 0; s < 256; s++)
            run_op(2'd3, s[7:0], 8'h00, -1, 0, 1'b0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule